// File: doc/BRIEF.md
# Reloadable Baud Rate Generator

This block turns a module clock into the bit-rate enables of a serial port that works either in asynchronous mode or in synchronous mode. A prescaler first divides the module clock, using one of two fixed ratios (2 or 3) or an accumulating fractional divider that passes on n out of every 512 clocks on average. Each prescaler enable steps a 13-bit down-counter. When the counter is at zero it loads the reload value and emits a one-cycle timer tick. A second divider turns those ticks into the bit-clock enable, passing one tick in 16 in asynchronous mode and one tick in 4 in synchronous mode.

Software sees one timer register. A read returns the live count. A write sets the reload value and asks for the count to be loaded from it. When the run bit is low the load waits until the run bit is next set, so the timer can be set up cleanly while it is stopped. The fractional value has its own register. The run bit, the prescaler selects and the mode bit are plain level inputs.

Top module: `baud_tick_gen`

## Requirements
- R1: While `run`=1, each prescaler enable decrements the 13-bit timer by one. When an enable finds the timer at 0, the timer loads the reload value and `tmr_tick` pulses for that one cycle. Steady tick spacing in module clocks is prescale × (reload + 1).
- R2: While `run`=0, the timer holds its value and `tmr_tick` and `bit_en` stay low. The prescaler counters and the bit counter are cleared.
- R3: `bit_en` pulses only together with `tmr_tick`. It passes every 16th tick when `sync_mode`=0 and every 4th tick when `sync_mode`=1. If the mode changes while the bit count is already at or past the new limit, the next tick emits `bit_en`.
- R4: When the fractional divider is not in use, `pre_sel`=0 divides the module clock by 2 and `pre_sel`=1 divides it by 3.
- R5: When `frac_en`=1 and `sync_mode`=0, a 9-bit accumulator adds n on every running clock and gives a prescaler enable on each carry past 511. The average ratio is n/512, and n = 0 gives no enable.
- R6: When `sync_mode`=1, `frac_en` has no effect and the fixed divider chosen by `pre_sel` is used.
- R7: `tmr_rdata` bits 12:0 always show the live timer count, and bits 31:13 always read 0.
- R8: A `tmr_wr` strobe while `run`=1 stores `tmr_wdata[12:0]` as the reload value and loads the timer with it at the same clock edge. No count or tick happens in that cycle. Bits 31:13 are ignored.
- R9: A `tmr_wr` strobe while `run`=0 updates only the reload value and leaves the timer unchanged. The timer loads the reload value at the first clock edge at which `run`=1, and it does not count in that cycle.
- R10: A `frac_wr` strobe stores `frac_wdata[8:0]` as n. Bits 31:9 are ignored.
- R11: After reset the timer, the reload value and n are 0, and `tmr_tick` and `bit_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run bit: 1 lets the prescaler and the timer advance |
| pre_sel | input | 1 | Fixed prescaler choice: 0 selects divide by 2, 1 selects divide by 3 |
| frac_en | input | 1 | Selects the fractional prescaler (asynchronous mode only) |
| sync_mode | input | 1 | 0 = asynchronous (bit divide 16), 1 = synchronous (bit divide 4) |
| tmr_wr | input | 1 | Write strobe for the timer/reload register |
| tmr_wdata | input | 32 | Write data; bits 12:0 hold the reload value |
| tmr_rdata | output | 32 | Live timer count in bits 12:0, zeros above |
| frac_wr | input | 1 | Write strobe for the fractional value register |
| frac_wdata | input | 32 | Write data; bits 8:0 hold n |
| tmr_tick | output | 1 | One-cycle pulse on each timer underflow |
| bit_en | output | 1 | One-cycle bit-clock enable |

## Verification
Tick spacing is measured with reload values of 0 and above, under each of the fixed ratios and under fractional values of 128 and 384. The value 384 gives an uneven carry pattern, so it catches a divider that only works for powers of two. The value 0 must give no ticks at all. The fractional select is also driven in synchronous mode, where the spacing must follow the fixed ratio. Writes are placed while the timer is stopped and while it runs, and the bench reads the live count back on the following cycle, which tells an immediate load from a deferred one. The mode is switched in both directions while the bit counter is part way through its count.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic [1:0] {
    SRC_FIX_A = 2'd0,
    SRC_FIX_B = 2'd1,
    SRC_FRAC  = 2'd2
  } pre_src_e;

  // Fractional divider is only honoured in asynchronous mode.
  function automatic pre_src_e pick_src(input logic sel_b, input logic frac_en,
                                        input logic sync_mode);
    if (frac_en && !sync_mode) return SRC_FRAC;
    return sel_b ? SRC_FIX_B : SRC_FIX_A;
  endfunction

endpackage

// File: rtl/bg_fixdiv.sv
module bg_fixdiv #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic en_o
);
  localparam int unsigned CW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  assign en_o = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (en_o)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bg_fracdiv.sv
module bg_fracdiv #(
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FRAC_W-1:0] step_n,
  output logic              en_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // One accumulation: carry out of the sum is the enable.
  function automatic logic [FRAC_W:0] acc_add(input logic [FRAC_W-1:0] a,
                                              input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum  = acc_add(acc_q, step_n);
  assign en_o = run && sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (!run) acc_q <= '0;
    else           acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale
  import bg_pkg::*;
#(
  parameter int unsigned FIX_A  = 2,
  parameter int unsigned FIX_B  = 3,
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sel_b,
  input  logic              frac_en,
  input  logic              sync_mode,
  input  logic [FRAC_W-1:0] frac_n,
  output logic              pre_en,
  output pre_src_e          src
);
  logic [1:0] fix_en;
  logic       frac_pulse;

  for (genvar g = 0; g < 2; g++) begin : g_fix
    bg_fixdiv #(.RATIO(g == 0 ? FIX_A : FIX_B)) u_fix (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .en_o (fix_en[g])
    );
  end

  bg_fracdiv #(.FRAC_W(FRAC_W)) u_frac (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .step_n(frac_n),
    .en_o  (frac_pulse)
  );

  assign src = pick_src(sel_b, frac_en, sync_mode);

  always_comb begin
    unique case (src)
      SRC_FIX_A: pre_en = fix_en[0];
      SRC_FIX_B: pre_en = fix_en[1];
      SRC_FRAC:  pre_en = frac_pulse;
      default:   pre_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/bg_timer.sv
module bg_timer #(
  parameter int unsigned TMR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_en,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  output logic [TMR_W-1:0] tmr_o,
  output logic [TMR_W-1:0] reload_o,
  output logic             load_o,
  output logic             tick_o
);
  logic [TMR_W-1:0] tmr_q, reload_q, load_val;
  logic             pend_q;

  function automatic logic [TMR_W-1:0] count_next(input logic [TMR_W-1:0] cur,
                                                  input logic [TMR_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign load_o   = run && (wr || pend_q);
  assign load_val = wr ? wdata : reload_q;
  assign tick_o   = run && pre_en && !load_o && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr) reload_q <= wdata;
      pend_q <= !run && (wr || pend_q);
      if (load_o)              tmr_q <= load_val;
      else if (run && pre_en)  tmr_q <= count_next(tmr_q, reload_q);
    end
  end

  assign tmr_o    = tmr_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/bg_bitdiv.sv
module bg_bitdiv #(
  parameter int unsigned ASYNC_DIV = 16,
  parameter int unsigned SYNC_DIV  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic sync_mode,
  output logic bit_en
);
  localparam int unsigned MAXD = (ASYNC_DIV > SYNC_DIV) ? ASYNC_DIV : SYNC_DIV;
  localparam int unsigned CW   = $clog2(MAXD);
  localparam logic [CW-1:0] LAST_A = CW'(ASYNC_DIV - 1);
  localparam logic [CW-1:0] LAST_S = CW'(SYNC_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = sync_mode ? LAST_S : LAST_A;
  assign bit_en = tick && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (bit_en) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bg_pkg::*;
#(
  parameter int unsigned TMR_W     = 13,
  parameter int unsigned FRAC_W    = 9,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned FIX_A     = 2,
  parameter int unsigned FIX_B     = 3,
  parameter int unsigned ASYNC_DIV = 16,
  parameter int unsigned SYNC_DIV  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic             frac_en,
  input  logic             sync_mode,
  input  logic             tmr_wr,
  input  logic [REG_W-1:0] tmr_wdata,
  output logic [REG_W-1:0] tmr_rdata,
  input  logic             frac_wr,
  input  logic [REG_W-1:0] frac_wdata,
  output logic             tmr_tick,
  output logic             bit_en
);
  logic [FRAC_W-1:0] frac_q;
  logic [TMR_W-1:0]  tmr_q, reload_q;
  logic              pre_en, load_now, tick;
  pre_src_e          src;
  logic              unused_hi;

  assign unused_hi = ^{tmr_wdata[REG_W-1:TMR_W], frac_wdata[REG_W-1:FRAC_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frac_q <= '0;
    else if (frac_wr) frac_q <= frac_wdata[FRAC_W-1:0];
  end

  bg_prescale #(.FIX_A(FIX_A), .FIX_B(FIX_B), .FRAC_W(FRAC_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sel_b    (pre_sel),
    .frac_en  (frac_en),
    .sync_mode(sync_mode),
    .frac_n   (frac_q),
    .pre_en   (pre_en),
    .src      (src)
  );

  bg_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pre_en  (pre_en),
    .wr      (tmr_wr),
    .wdata   (tmr_wdata[TMR_W-1:0]),
    .tmr_o   (tmr_q),
    .reload_o(reload_q),
    .load_o  (load_now),
    .tick_o  (tick)
  );

  bg_bitdiv #(.ASYNC_DIV(ASYNC_DIV), .SYNC_DIV(SYNC_DIV)) u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .sync_mode(sync_mode),
    .bit_en   (bit_en)
  );

  assign tmr_tick  = tick;
  assign tmr_rdata = {{(REG_W-TMR_W){1'b0}}, tmr_q};
endmodule

// File: rtl/bg_checker.sv
module bg_checker
  import bg_pkg::*;
#(
  parameter int unsigned TMR_W  = 13,
  parameter int unsigned FRAC_W = 9,
  parameter int unsigned REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              sync_mode,
  input logic              tmr_wr,
  input logic [REG_W-1:0]  tmr_wdata,
  input logic [REG_W-1:0]  tmr_rdata,
  input logic              tick,
  input logic              bit_en,
  input logic              pre_en,
  input logic              load_now,
  input logic [TMR_W-1:0]  reload_q,
  input logic [FRAC_W-1:0] frac_q,
  input pre_src_e          src
);
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rdata[REG_W-1:TMR_W] == '0);

  assert_reload_on_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_rdata[TMR_W-1:0] == $past(reload_q));

  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pre_en && !load_now && tmr_rdata[TMR_W-1:0] != '0)
      |=> tmr_rdata[TMR_W-1:0] == $past(tmr_rdata[TMR_W-1:0]) - 1'b1);

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(tmr_rdata));

  assert_quiet_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tick && !bit_en));

  assert_bit_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> tick);

  assert_frac_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_FRAC && frac_q == '0) |-> !pre_en);

  assert_sync_no_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> src != SRC_FRAC);

  assert_write_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && run) |=> tmr_rdata[TMR_W-1:0] == $past(tmr_wdata[TMR_W-1:0]));

  assert_deferred_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !tmr_wr) |=> tmr_rdata[TMR_W-1:0] == $past(reload_q));
endmodule

bind baud_tick_gen bg_checker #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .REG_W(REG_W)) u_bg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .sync_mode(sync_mode),
  .tmr_wr   (tmr_wr),
  .tmr_wdata(tmr_wdata),
  .tmr_rdata(tmr_rdata),
  .tick     (tick),
  .bit_en   (bit_en),
  .pre_en   (pre_en),
  .load_now (load_now),
  .reload_q (reload_q),
  .frac_q   (frac_q),
  .src      (src)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, pre_sel = 1'b0, frac_en = 1'b0, sync_mode = 1'b0;
  logic        tmr_wr = 1'b0, frac_wr = 1'b0;
  logic [31:0] tmr_wdata = '0, frac_wdata = '0;
  logic [31:0] tmr_rdata;
  logic        tmr_tick, bit_en;

  int vectors = 0, miscompares = 0;
  int cyc = 0, tick_cnt = 0, bit_cnt = 0, orphan_bits = 0;
  int last_tick = 0, tick_gap_v = 0, last_bit = 0, bit_gap_v = 0;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .frac_en(frac_en),
    .sync_mode(sync_mode), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .tmr_rdata(tmr_rdata), .frac_wr(frac_wr), .frac_wdata(frac_wdata),
    .tmr_tick(tmr_tick), .bit_en(bit_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Event monitor, sampled mid-cycle.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tmr_tick) begin
      tick_gap_v <= cyc - last_tick;
      last_tick  <= cyc;
      tick_cnt   <= tick_cnt + 1;
    end
    if (bit_en) begin
      bit_gap_v <= cyc - last_bit;
      last_bit  <= cyc;
      bit_cnt   <= bit_cnt + 1;
      if (!tmr_tick) orphan_bits <= orphan_bits + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic r, input logic sb, input logic fe, input logic sm);
    @(posedge clk); #1;
    run = r; pre_sel = sb; frac_en = fe; sync_mode = sm;
  endtask

  task automatic wr_tmr(input logic [31:0] d);
    @(posedge clk); #1; tmr_wr = 1'b1; tmr_wdata = d;
    @(posedge clk); #1; tmr_wr = 1'b0;
  endtask

  task automatic wr_frac(input logic [31:0] d);
    @(posedge clk); #1; frac_wr = 1'b1; frac_wdata = d;
    @(posedge clk); #1; frac_wr = 1'b0;
  endtask

  // Wait for two new ticks, return spacing of the latter (-1 on timeout).
  task automatic tick_gap(output int g);
    int c0 = tick_cnt;
    int n = 0;
    while (tick_cnt < c0 + 2 && n < 5000) begin @(posedge clk); n++; end
    g = (tick_cnt >= c0 + 2) ? tick_gap_v : -1;
  endtask

  task automatic bit_gap(output int g);
    int c0 = bit_cnt;
    int n = 0;
    while (bit_cnt < c0 + 2 && n < 5000) begin @(posedge clk); n++; end
    g = (bit_cnt >= c0 + 2) ? bit_gap_v : -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 timer after reset", int'(tmr_rdata), 0);
    check("R11 tick after reset", int'(tmr_tick), 0);
    check("R11 bit_en after reset", int'(bit_en), 0);
  endtask

  task automatic t_fixed();
    int g;
    wr_tmr(32'd0);
    cfg(1, 0, 0, 0);
    tick_gap(g); check("R1 reload 0, div 2", g, 2);
    cfg(0, 0, 0, 0);
    wr_tmr(32'd5);
    cfg(1, 0, 0, 0);
    tick_gap(g); check("R4 div 2 reload 5", g, 12);
    cfg(1, 1, 0, 0);
    tick_gap(g); check("R4 div 3 reload 5", g, 18);
  endtask

  task automatic t_frac();
    int g, c0;
    cfg(0, 0, 1, 0);
    wr_frac(32'hFFFF_FE80);          // n = 128, upper bits ignored
    wr_tmr(32'd3);
    cfg(1, 0, 1, 0);
    tick_gap(g); check("R10/R5 n=128 reload 3", g, 16);
    cfg(0, 0, 1, 0);
    wr_frac(32'd384);
    wr_tmr(32'd2);
    cfg(1, 0, 1, 0);
    tick_gap(g); check("R5 n=384 reload 2", g, 4);
    wr_frac(32'd0);
    repeat (4) @(posedge clk);
    c0 = tick_cnt;
    repeat (300) @(posedge clk);
    check("R5 n=0 gives no ticks", tick_cnt - c0, 0);
  endtask

  task automatic t_sync_frac();
    int g;
    cfg(0, 1, 1, 1);
    wr_frac(32'd128);
    wr_tmr(32'd1);
    cfg(1, 1, 1, 1);
    tick_gap(g); check("R6 frac ignored in sync, div 3", g, 6);
  endtask

  task automatic t_modes();
    int g;
    cfg(0, 0, 0, 0);
    wr_tmr(32'd0);
    cfg(1, 0, 0, 0);
    bit_gap(g); check("R3 async bit spacing", g, 32);
    cfg(1, 0, 0, 1);
    bit_gap(g); check("R3 sync bit spacing", g, 8);
    cfg(1, 0, 0, 0);
    bit_gap(g); check("R3 back to async", g, 32);
    check("R3 bit_en without tick", orphan_bits, 0);
  endtask

  task automatic t_stop();
    int v1, c0, b0, a, b;
    cfg(0, 0, 0, 0);
    wr_tmr(32'd500);
    cfg(1, 0, 0, 0);
    repeat (10) @(posedge clk);
    @(negedge clk); a = int'(tmr_rdata);
    @(negedge clk); @(negedge clk); b = int'(tmr_rdata);
    check("R7 live count drops 1 per 2 cycles", a - b, 1);
    check("R7 upper read bits zero", int'(tmr_rdata >> 13), 0);
    cfg(0, 0, 0, 0);
    @(negedge clk); v1 = int'(tmr_rdata);
    c0 = tick_cnt; b0 = bit_cnt;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R2 timer holds while stopped", int'(tmr_rdata), v1);
    check("R2 no ticks while stopped", tick_cnt - c0, 0);
    check("R2 no bit_en while stopped", bit_cnt - b0, 0);
  endtask

  task automatic t_write_stopped();
    int v_old;
    @(negedge clk); v_old = int'(tmr_rdata);
    wr_tmr(32'd100);
    @(negedge clk);
    check("R9 stopped write leaves timer", int'(tmr_rdata), v_old);
    cfg(1, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    check("R9 load on first running cycle", int'(tmr_rdata), 100);
  endtask

  task automatic t_write_running();
    int g;
    repeat (20) @(posedge clk);
    wr_tmr(32'hABCD_E007);           // bits 12:0 = 7
    @(negedge clk);
    check("R8 running write loads at once", int'(tmr_rdata), 7);
    tick_gap(g); check("R8 spacing after running write", g, 16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_frac();
    t_sync_frac();
    t_modes();
    t_stop();
    t_write_stopped();
    t_write_running();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule